// File: doc/BRIEF.md
# Load/Store Address Classifier with Stall Control

This block sits between a two-slot CPU load/store port and the data cache. Each cycle it sorts every valid request address into one of four classes: cacheable SDRAM, non-cacheable SDRAM, register space, or the external peripheral bus. The register space is a window of fixed 2 MB size whose base is programmable. The SDRAM window and the non-cacheable sub-window are each given by a programmable lower bound and limit. From these classes and from the cache and completion handshakes, the block drives one CPU stall line.

Stall covers several cases. It is raised for uncached accesses until they signal completion, for cache misses, and for a bank collision between two cacheable requests issued in the same cycle. It is also raised for copyback or invalidate work that has something to do. After reset, a sweep steps through every cache line index, one index per cycle, to clear the valid and dirty bits. Stall stays high until the sweep ends. Each request that is served raises its response-valid strobe a fixed three cycles later.

Top module: `mem_stall_ctrl`

## Requirements
- R1: An address is classed as register space (region code 2) when mmio_base <= addr < mmio_base + 0x200000, with the compare done without wraparound. The 2 MB size is fixed, and moving mmio_base moves the window.
- R2: An address with sdram_lo <= addr < sdram_hi is SDRAM. It gets code 1 (non-cacheable) when it also satisfies nc_lo <= addr < nc_hi, and code 0 (cacheable) otherwise. Register space takes priority over both SDRAM codes.
- R3: Any address in neither the SDRAM window nor the register window gets code 3 (external bus).
- R4: A valid request with code 1, 2 or 3 holds stall high in every cycle where unc_done is low. It is served in the first cycle where unc_done is high and no other cause stalls.
- R5: A valid code-0 request whose cache_hit bit is low holds stall high. It is served once cache_hit rises.
- R6: The bank is address bits [3:2]. When both slots carry hitting code-0 requests to the same bank, stall is high for exactly one cycle and slot 0 is served in that cycle. Slot 1 is served in the next cycle, with stall low. Requests to different banks are both served at once with no stall.
- R7: While cmo_valid and cmo_work are high and cmo_done is low, stall is high. A copyback or invalidate with cmo_work low causes no stall.
- R8: After reset is released, init_clr is high with init_idx = 0, 1, ..., LINES-1 in successive cycles. Stall is high in each of those cycles. In the following cycle stall is low and init_done is high, and init_done stays high.
- R9: rsp_valid[s] pulses exactly three cycles after the cycle in which slot s is served, whatever the class of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mmio_base | input | 32 | Base of the register window |
| sdram_lo | input | 32 | SDRAM window lower bound (inclusive) |
| sdram_hi | input | 32 | SDRAM window limit (exclusive) |
| nc_lo | input | 32 | Non-cacheable sub-window lower bound |
| nc_hi | input | 32 | Non-cacheable sub-window limit (exclusive) |
| req_valid | input | 2 | Request present, one bit per slot |
| req_addr | input | 64 | Request addresses, slot s in bits [32s+31:32s] |
| cache_hit | input | 2 | Cache hit, one bit per slot |
| unc_done | input | 1 | Uncached access completes this cycle |
| cmo_valid | input | 1 | Copyback or invalidate operation present |
| cmo_work | input | 1 | That operation has lines to process |
| cmo_done | input | 1 | That operation finishes this cycle |
| region | output | 4 | Region code per slot, slot s in bits [2s+1:2s] |
| stall | output | 1 | CPU stall |
| rsp_valid | output | 2 | Result valid per slot, three cycles after service |
| init_clr | output | 1 | Reset sweep clears the line at init_idx |
| init_idx | output | 6 | Line index being cleared |
| init_done | output | 1 | Reset sweep finished |

## Verification
The decoder is driven with a table of addresses placed on both sides of every window edge. The table includes a non-cacheable range that straddles the register window, so it separates an off-by-one bound from a wrong priority order. The register base is then moved to the top of the address space, which tests the fixed size and the no-wrap compare. For stalls, the bench compares a same-bank pair with a different-bank pair, and a long miss or uncached wait with an immediate one. It also compares a copyback that has work with one that has none. Response-strobe timing tells the two slots apart in a collision.

// File: rtl/msc_pkg.sv
package msc_pkg;
   typedef enum logic [1:0] {
      RG_SDRAM  = 2'd0,
      RG_NCDRAM = 2'd1,
      RG_MMIO   = 2'd2,
      RG_EXT    = 2'd3
   } region_e;

   localparam int NSLOT       = 2;
   localparam int APER_LOG2   = 21;
endpackage

// File: rtl/msc_decode.sv
module msc_decode
   import msc_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] mmio_base,
   input  logic [AW-1:0] sdram_lo,
   input  logic [AW-1:0] sdram_hi,
   input  logic [AW-1:0] nc_lo,
   input  logic [AW-1:0] nc_hi,
   output region_e       region
);
   localparam logic [AW:0] APER = (AW+1)'(1) << APER_LOG2;

   if (AW <= APER_LOG2) begin : g_bad_aw
      $error("msc_decode: AW must exceed the aperture width");
   end

   logic [AW:0] a_ext, base_ext;
   logic        in_mmio, in_sd, in_nc;

   always_comb begin
      a_ext    = {1'b0, addr};
      base_ext = {1'b0, mmio_base};
      in_mmio  = (a_ext >= base_ext) && (a_ext < base_ext + APER);
      in_sd    = (addr >= sdram_lo) && (addr < sdram_hi);
      in_nc    = (addr >= nc_lo) && (addr < nc_hi);
      if (in_mmio)    region = RG_MMIO;
      else if (in_sd) region = in_nc ? RG_NCDRAM : RG_SDRAM;
      else            region = RG_EXT;
   end
endmodule

// File: rtl/msc_init_seq.sv
module msc_init_seq #(
   parameter int LINES = 64,
   localparam int IW   = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          busy,
   output logic [IW-1:0] idx
);
   if (LINES < 2) begin : g_bad_lines
      $error("msc_init_seq: LINES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (busy) begin
         if (idx == IW'(LINES-1)) busy <= 1'b0;
         else                     idx  <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/msc_lat_pipe.sv
module msc_lat_pipe #(
   parameter int NS  = 2,
   parameter int LAT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NS-1:0] d,
   output logic [NS-1:0] q
);
   if (LAT < 0 || LAT > 16) begin : g_bad_lat
      $error("msc_lat_pipe: LAT out of range");
   end

   if (LAT == 0) begin : g_comb
      assign q = d;
   end else begin : g_reg
      logic [NS-1:0] stg [LAT];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < LAT; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[LAT-1];
   end
endmodule

// File: rtl/mem_stall_ctrl.sv
module mem_stall_ctrl
   import msc_pkg::*;
#(
   parameter int AW       = 32,
   parameter int LINES    = 64,
   parameter int LAT      = 3,
   parameter int BANK_LSB = 2,
   parameter int BANK_W   = 2,
   localparam int IW      = $clog2(LINES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [AW-1:0]       mmio_base,
   input  logic [AW-1:0]       sdram_lo,
   input  logic [AW-1:0]       sdram_hi,
   input  logic [AW-1:0]       nc_lo,
   input  logic [AW-1:0]       nc_hi,
   input  logic [NSLOT-1:0]    req_valid,
   input  logic [NSLOT*AW-1:0] req_addr,
   input  logic [NSLOT-1:0]    cache_hit,
   input  logic                unc_done,
   input  logic                cmo_valid,
   input  logic                cmo_work,
   input  logic                cmo_done,
   output logic [NSLOT*2-1:0]  region,
   output logic                stall,
   output logic [NSLOT-1:0]    rsp_valid,
   output logic                init_clr,
   output logic [IW-1:0]       init_idx,
   output logic                init_done
);
   if (BANK_LSB + BANK_W > AW) begin : g_bad_bank
      $error("mem_stall_ctrl: bank field outside the address");
   end

   region_e           rg     [NSLOT];
   logic [BANK_W-1:0] bank   [NSLOT];
   logic [NSLOT-1:0]  cach, unc, served;
   logic              init_busy, miss, unc_wait, cmo_wait;
   logic              conflict, other, second_q, second_now;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      msc_decode #(.AW(AW)) u_dec (
         .addr      (req_addr[s*AW +: AW]),
         .mmio_base (mmio_base),
         .sdram_lo  (sdram_lo),
         .sdram_hi  (sdram_hi),
         .nc_lo     (nc_lo),
         .nc_hi     (nc_hi),
         .region    (rg[s])
      );
      assign region[s*2 +: 2] = rg[s];
      assign cach[s] = req_valid[s] && (rg[s] == RG_SDRAM);
      assign unc[s]  = req_valid[s] && (rg[s] != RG_SDRAM);
      assign bank[s] = req_addr[s*AW + BANK_LSB +: BANK_W];
   end

   msc_init_seq #(.LINES(LINES)) u_init (
      .clk   (clk),
      .rst_n (rst_n),
      .busy  (init_busy),
      .idx   (init_idx)
   );

   always_comb begin
      miss       = |(cach & ~cache_hit);
      unc_wait   = (|unc) && !unc_done;
      cmo_wait   = cmo_valid && cmo_work && !cmo_done;
      conflict   = (&cach) && (bank[0] == bank[1]);
      other      = init_busy || unc_wait || miss || cmo_wait;
      second_now = second_q && conflict;
      stall      = other || (conflict && !second_q);
      served[0]  = req_valid[0] && !other && !second_now;
      served[1]  = req_valid[1] && !other && !(conflict && !second_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) second_q <= 1'b0;
      else        second_q <= conflict && !other && !second_q;
   end

   msc_lat_pipe #(.NS(NSLOT), .LAT(LAT)) u_lat (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (served),
      .q     (rsp_valid)
   );

   assign init_clr  = init_busy;
   assign init_done = !init_busy;
endmodule

// File: rtl/mem_stall_ctrl_chk.sv
module mem_stall_ctrl_chk #(
   parameter int LAT = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] req_valid,
   input logic [1:0] cache_hit,
   input logic [3:0] region,
   input logic       unc_done,
   input logic       cmo_valid,
   input logic       cmo_work,
   input logic       cmo_done,
   input logic       stall,
   input logic       init_done,
   input logic [1:0] served,
   input logic [1:0] rsp_valid
);
   // R8
   init_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> stall);

   // R8
   init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   // R4
   unc_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[0] && region[1:0] != 2'd0 && !unc_done) |-> stall);

   // R5
   miss_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[0] && region[1:0] == 2'd0 && !cache_hit[0]) |-> stall);

   // R7
   cmo_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmo_valid && cmo_work && !cmo_done) |-> stall);

   // R6
   slot1_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      served[1] |-> !stall);

   if (LAT == 3) begin : g_lat3
      // R9
      rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         served[0] |-> ##3 rsp_valid[0]);
   end
endmodule

bind mem_stall_ctrl mem_stall_ctrl_chk #(.LAT(LAT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .cache_hit (cache_hit),
   .region    (region),
   .unc_done  (unc_done),
   .cmo_valid (cmo_valid),
   .cmo_work  (cmo_work),
   .cmo_done  (cmo_done),
   .stall     (stall),
   .init_done (init_done),
   .served    (served),
   .rsp_valid (rsp_valid)
);

// File: tb/mem_stall_ctrl_tb.sv
module mem_stall_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LINES      = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mmio_base, sdram_lo, sdram_hi, nc_lo, nc_hi;
   logic [1:0]  req_valid, cache_hit;
   logic [63:0] req_addr;
   logic        unc_done, cmo_valid, cmo_work, cmo_done;
   logic [3:0]  region;
   logic        stall, init_clr, init_done;
   logic [1:0]  rsp_valid;
   logic [5:0]  init_idx;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mem_stall_ctrl #(.LINES(LINES)) u_dut (
      .clk(clk), .rst_n(rst_n), .mmio_base(mmio_base), .sdram_lo(sdram_lo),
      .sdram_hi(sdram_hi), .nc_lo(nc_lo), .nc_hi(nc_hi), .req_valid(req_valid),
      .req_addr(req_addr), .cache_hit(cache_hit), .unc_done(unc_done),
      .cmo_valid(cmo_valid), .cmo_work(cmo_work), .cmo_done(cmo_done),
      .region(region), .stall(stall), .rsp_valid(rsp_valid),
      .init_clr(init_clr), .init_idx(init_idx), .init_done(init_done)
   );

   // address, expected region code, requirement
   localparam int NV = 12;
   localparam logic [31:0] V_ADDR [NV] = '{
      32'h1000_0000, 32'h13FF_FFFC, 32'h1400_0000, 32'h0FFF_FFFC,
      32'h1280_0000, 32'h12FF_FFFC, 32'h1300_0000, 32'h131F_FFFC,
      32'h1320_0000, 32'h133F_FFFC, 32'h1340_0000, 32'hFFFF_FFFC};
   localparam logic [1:0] V_EXP [NV] = '{
      2'd0, 2'd0, 2'd3, 2'd3, 2'd1, 2'd1, 2'd2, 2'd2, 2'd1, 2'd1, 2'd0, 2'd3};
   localparam string V_REQ [NV] = '{
      "R2", "R2", "R3", "R3", "R2", "R2", "R1", "R1", "R2", "R2", "R2", "R3"};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic idle();
      req_valid = 2'b00; cache_hit = 2'b00; unc_done = 1'b0;
      cmo_valid = 1'b0; cmo_work = 1'b0; cmo_done = 1'b0;
   endtask

   // served in the current cycle: rsp must be low for two samples, high on the third
   task automatic rsp_after(input string req, input int slot);
      for (int k = 1; k <= 3; k++) begin
         step(); idle(); #1;
         chk(req, 32'(rsp_valid[slot]), (k == 3) ? 32'd1 : 32'd0);
      end
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      if (!finished) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      mmio_base = 32'h1300_0000; sdram_lo = 32'h1000_0000; sdram_hi = 32'h1400_0000;
      nc_lo = 32'h1280_0000; nc_hi = 32'h1340_0000;
      req_addr = '0; idle();
      #(CLK_PERIOD*2);
      @(negedge clk); rst_n = 1'b1; #1;

      // R8: reset sweep
      for (int i = 0; i < LINES; i++) begin
         chk("R8 stall", 32'(stall), 32'd1);
         chk("R8 clr", 32'(init_clr), 32'd1);
         chk("R8 idx", 32'(init_idx), 32'(i));
         step(); #1;
      end
      chk("R8 done", 32'(init_done), 32'd1);
      chk("R8 stall low", 32'(stall), 32'd0);

      // R1 R2 R3: decode table on slot 0
      for (int v = 0; v < NV; v++) begin
         req_addr[31:0] = V_ADDR[v]; #1;
         chk(V_REQ[v], 32'(region[1:0]), 32'(V_EXP[v]));
      end
      // R1: moved base, top of space, no wrap
      mmio_base = 32'hFFE0_0000;
      req_addr[31:0] = 32'hFFFF_FFFC; #1; chk("R1 top", 32'(region[1:0]), 32'd2);
      req_addr[31:0] = 32'hFFDF_FFFC; #1; chk("R1 below", 32'(region[1:0]), 32'd3);
      req_addr[31:0] = 32'h0000_0000; #1; chk("R1 nowrap", 32'(region[1:0]), 32'd3);
      mmio_base = 32'h1300_0000;
      step();

      // R5 + R9: hit served at once
      req_valid = 2'b01; req_addr[31:0] = 32'h1000_0040; cache_hit = 2'b01; #1;
      chk("R5 hit", 32'(stall), 32'd0);
      rsp_after("R9 hit", 0);

      // R5: miss for three cycles
      step(); req_valid = 2'b01; req_addr[31:0] = 32'h1000_0080; cache_hit = 2'b00;
      for (int k = 0; k < 3; k++) begin
         #1; chk("R5 miss", 32'(stall), 32'd1);
         chk("R5 no rsp", 32'(rsp_valid), 32'd0);
         step();
      end
      cache_hit = 2'b01; #1; chk("R5 fill", 32'(stall), 32'd0);
      rsp_after("R9 miss", 0);

      // R4: register, external and non-cacheable waits
      begin
         logic [31:0] ua [3] = '{32'h1300_0010, 32'h2000_0000, 32'h1290_0000};
         for (int u = 0; u < 3; u++) begin
            step(); req_valid = 2'b01; req_addr[31:0] = ua[u]; unc_done = 1'b0;
            #1; chk("R4 wait", 32'(stall), 32'd1);
            step(); #1; chk("R4 wait2", 32'(stall), 32'd1);
            step(); unc_done = 1'b1; #1; chk("R4 done", 32'(stall), 32'd0);
            rsp_after("R9 unc", 0);
         end
      end

      // R6: same bank collision
      step(); req_valid = 2'b11; cache_hit = 2'b11;
      req_addr = {32'h1000_0104, 32'h1000_0004}; #1;
      chk("R6 first", 32'(stall), 32'd1);
      step(); #1; chk("R6 second", 32'(stall), 32'd0);
      chk("R6 slot0 rsp pending", 32'(rsp_valid), 32'd0);
      step(); idle(); #1; chk("R6 none", 32'(rsp_valid), 32'd0);
      step(); #1; chk("R6 slot0 first", 32'(rsp_valid), 32'b01);
      step(); #1; chk("R6 slot1 next", 32'(rsp_valid), 32'b10);

      // R6: different banks
      step(); req_valid = 2'b11; cache_hit = 2'b11;
      req_addr = {32'h1000_0108, 32'h1000_0004}; #1;
      chk("R6 diff bank", 32'(stall), 32'd0);
      step(); idle(); #1;
      step(); #1;
      step(); #1; chk("R6 both rsp", 32'(rsp_valid), 32'b11);

      // R7: copyback with and without work
      step(); idle(); cmo_valid = 1'b1; cmo_work = 1'b1; #1;
      chk("R7 work", 32'(stall), 32'd1);
      step(); #1; chk("R7 work2", 32'(stall), 32'd1);
      step(); cmo_done = 1'b1; #1; chk("R7 done", 32'(stall), 32'd0);
      step(); idle(); cmo_valid = 1'b1; cmo_work = 1'b0; #1;
      chk("R7 trivial", 32'(stall), 32'd0);
      step(); idle(); #1;
      chk("R8 done held", 32'(init_done), 32'd1);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule